// File: doc/BRIEF.md
# Alarm-Driven Power Enable Controller

This block owns the external power-enable output of a chip that keeps a calendar running while the rest of the system is powered down. Software writes a full date and time into a set of second-alarm fields, which the block presents to a calendar comparator outside it. When that comparator reports a match with a one-cycle pulse, the block records the event in a sticky status bit and can raise an interrupt. If power control is armed, the same pulse drives the power-enable output to the off level.

Four external wake pins can bring power back. Each pin has its own enable bit and its own polarity bit. Each pin passes through a two-stage synchronizer. While power is off, any enabled pin at its active level drives the power-enable output on again.

The bus is a plain single-cycle register port with no handshake. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from `reg_addr`. No stream flows through the block, so every pin is a plain control or status signal.

Top module: `pwr_alarm_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1 and `alarm2_irq` is 0. The status register reads 0. The power control register reads 0x000000F0: every wake input is disabled and set to active low, and power control is disarmed.
- R2: Six 8-bit second-alarm fields sit at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. Each field stores `reg_wdata[7:0]` and reads back zero-extended. `alarm2_time` presents the fields packed with seconds in bits [7:0] and year in bits [47:40].
- R3: An `alarm2_hit` pulse sets status bit 0 (offset 0x1C) on the next edge, and the bit stays set. Writing 1 to that bit clears it. Writing 0 leaves it unchanged. If a hit and a clear arrive in the same cycle, the bit stays set.
- R4: `alarm2_irq` is high exactly while status bit 0 and interrupt-enable bit 0 (offset 0x18) are both 1.
- R5: The power control register is at offset 0x20, and its bit 16 arms power control. When bit 16 is 1, `alarm2_hit` drives `pwr_en` to 0 on the next edge. When bit 16 is 0, a hit leaves `pwr_en` unchanged.
- R6: In the power control register, bit i (i = 0..3) enables wake pin i. While `pwr_en` is 0, an enabled pin held at its active level sets `pwr_en` to 1 on the third clock edge after the pin changes: two synchronizer stages, then the output register.
- R7: Bit 4+i of the power control register sets the polarity of wake pin i. A value of 1 makes a low level active, and 0 makes a high level active.
- R8: A disabled wake pin never turns power on, whatever its level.
- R9: When an armed hit and an active wake pin occur in the same cycle, `pwr_en` stays or goes 0. It turns on only in a later cycle that has no hit.
- R10: Bits of the power control register other than 0-7 and 16 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| alarm2_hit | input | 1 | One-cycle match pulse from the calendar comparator |
| wake_pin | input | 4 | Asynchronous external wake inputs |
| alarm2_time | output | 48 | Packed second-alarm fields for the comparator |
| alarm2_irq | output | 1 | Second-alarm interrupt |
| pwr_en | output | 1 | External power-enable, 1 = on |

## Verification
Some properties are checked on every cycle:
- An armed hit always turns power off on the next edge.
- Power only ever falls after an armed hit, and only ever rises after a synchronized, enabled, active wake level.
- A hit always sets the status bit.
- A hit always raises the interrupt when the interrupt is enabled.

Other behaviour can only be shown by the bench's scenarios. These cover the reset values, field storage and packing, and the write-one-to-clear and write-zero cases of the status bit. They also cover the three-edge wake latency, every enable and polarity combination, the priority of a hit over a wake, and the masking of unused control bits.

// File: rtl/pwr_alarm_pkg.sv
package pwr_alarm_pkg;
  localparam int NWAKE      = 4;
  localparam int NFIELD     = 6;
  localparam int FIELD_W    = 8;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 32;
  localparam logic [ADDR_W-1:0] ALM_BASE  = 6'h00;
  localparam logic [ADDR_W-1:0] IEN_ADDR  = 6'h18;
  localparam logic [ADDR_W-1:0] STS_ADDR  = 6'h1C;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 6'h20;
  localparam int CTRL_ARM_BIT = 16;
endpackage

// File: rtl/pwr_alarm_regs.sv
module pwr_alarm_regs
  import pwr_alarm_pkg::*;
#(
  parameter int NW = NWAKE,
  parameter int NF = NFIELD,
  parameter int FW = FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hit,
  output logic [DATA_W-1:0] rdata,
  output logic [NF*FW-1:0]  alm_time,
  output logic              irq_en,
  output logic              sts,
  output logic              arm,
  output logic [NW-1:0]     wen,
  output logic [NW-1:0]     wpol
);
  logic [FW-1:0] fld [NF];

  for (genvar i = 0; i < NF; i++) begin : g_fld
    localparam logic [ADDR_W-1:0] FA = ALM_BASE + ADDR_W'(4*i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fld[i] <= '0;
      else if (wr && addr == FA) fld[i] <= wdata[FW-1:0];
    end
    assign alm_time[i*FW +: FW] = fld[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      sts    <= 1'b0;
      arm    <= 1'b0;
      wen    <= '0;
      wpol   <= '1;
    end else begin
      if (hit) sts <= 1'b1;
      else if (wr && addr == STS_ADDR && wdata[0]) sts <= 1'b0;
      if (wr && addr == IEN_ADDR) irq_en <= wdata[0];
      if (wr && addr == CTRL_ADDR) begin
        arm  <= wdata[CTRL_ARM_BIT];
        wen  <= wdata[NW-1:0];
        wpol <= wdata[2*NW-1:NW];
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NF; i++)
      if (addr == ALM_BASE + ADDR_W'(4*i)) rdata[FW-1:0] = fld[i];
    if (addr == IEN_ADDR) rdata[0] = irq_en;
    if (addr == STS_ADDR) rdata[0] = sts;
    if (addr == CTRL_ADDR) begin
      rdata[CTRL_ARM_BIT] = arm;
      rdata[NW-1:0]       = wen;
      rdata[2*NW-1:NW]    = wpol;
    end
  end
endmodule

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NW-1:0] pin,
  input  logic [NW-1:0] en,
  input  logic [NW-1:0] pol_low,
  output logic          any_act
);
  logic [NW-1:0] act;

  for (genvar i = 0; i < NW; i++) begin : g_pin
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= pin[i];
        s2 <= s1;
      end
    end
    assign act[i] = en[i] & (s2 ^ pol_low[i]);
  end

  assign any_act = |act;
endmodule

// File: rtl/pwr_out_ctl.sv
module pwr_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic hit,
  input  logic wake,
  output logic pwr_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_en <= 1'b1;
    else if (arm && hit) pwr_en <= 1'b0;
    else if (!pwr_en && wake) pwr_en <= 1'b1;
  end
endmodule

// File: rtl/pwr_alarm_ctrl.sv
module pwr_alarm_ctrl
  import pwr_alarm_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic                      alarm2_hit,
  input  logic [NWAKE-1:0]          wake_pin,
  output logic [NFIELD*FIELD_W-1:0] alarm2_time,
  output logic                      alarm2_irq,
  output logic                      pwr_en
);
  logic             irq_en, sts, arm, wake_any;
  logic [NWAKE-1:0] wen, wpol;

  pwr_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .hit(alarm2_hit), .rdata(reg_rdata), .alm_time(alarm2_time),
    .irq_en(irq_en), .sts(sts), .arm(arm), .wen(wen), .wpol(wpol)
  );

  pwr_wake_sync #(.NW(NWAKE)) u_wake (
    .clk(clk), .rst_n(rst_n), .pin(wake_pin), .en(wen), .pol_low(wpol),
    .any_act(wake_any)
  );

  pwr_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(alarm2_hit), .wake(wake_any),
    .pwr_en(pwr_en)
  );

  assign alarm2_irq = sts & irq_en;
endmodule

// File: rtl/pwr_alarm_chk.sv
module pwr_alarm_chk (
  input logic clk,
  input logic rst_n,
  input logic alarm2_hit,
  input logic arm,
  input logic irq_en,
  input logic sts,
  input logic wake_any,
  input logic alarm2_irq,
  input logic pwr_en
);
  a_r5_armed_hit_off: assert property (@(posedge clk) disable iff (!rst_n)
    arm && alarm2_hit |=> !pwr_en);
  a_r5_fall_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(arm && alarm2_hit));
  a_r6_rise_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(wake_any));
  a_r3_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    alarm2_hit |=> sts);
  a_r4_irq_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    alarm2_hit && irq_en |=> alarm2_irq);
endmodule

bind pwr_alarm_ctrl pwr_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alarm2_hit(alarm2_hit), .arm(arm),
  .irq_en(irq_en), .sts(sts), .wake_any(wake_any),
  .alarm2_irq(alarm2_irq), .pwr_en(pwr_en)
);

// File: tb/pwr_alarm_ctrl_tb.sv
module pwr_alarm_ctrl_tb;
  logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, alarm2_hit = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  wake_pin = '0;
  logic [47:0] alarm2_time;
  logic        alarm2_irq, pwr_en;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pwr_alarm_ctrl u_dut (.*);

  // {enable[3:0], polarity[3:0], pins[3:0], expect power on}
  localparam logic [12:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b0001, 1'b1},
    {4'b0001, 4'b0000, 4'b0000, 1'b0},
    {4'b0001, 4'b0001, 4'b0000, 1'b1},
    {4'b0001, 4'b0001, 4'b0001, 1'b0},
    {4'b0000, 4'b0000, 4'b1111, 1'b0},
    {4'b1000, 4'b1000, 4'b0111, 1'b1},
    {4'b0110, 4'b1111, 4'b1111, 1'b0},
    {4'b0100, 4'b0000, 4'b0100, 1'b1}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse_hit();
    @(negedge clk); alarm2_hit = 1'b1;
    @(negedge clk); alarm2_hit = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R1 pwr_en", pwr_en, 1);
    check("R1 irq", alarm2_irq, 0);
    rst_n = 1'b1;
    rd(6'h20, d); check("R1 ctrl", d, 32'hF0);
    rd(6'h1C, d); check("R1 status", d, 0);

    // R10: unused control bits masked
    wr(6'h20, 32'hFFFF_FF00);
    rd(6'h20, d); check("R10 ctrl mask", d, 32'h0001_0000);

    // R2: alarm field storage and packing
    for (int i = 0; i < 6; i++) wr(6'(4*i), 32'hABCD_0010 + 32'(i * 17));
    for (int i = 0; i < 6; i++) begin
      rd(6'(4*i), d); check("R2 field", d, 32'h10 + 32'(i * 17));
    end
    check("R2 packing", alarm2_time, 48'h65_54_43_32_21_10);

    // R5: disarmed hit leaves power on; R3 status set
    wr(6'h20, 32'h0);
    pulse_hit();
    check("R5 disarmed", pwr_en, 1);
    rd(6'h1C, d); check("R3 set", d, 1);
    check("R4 irq disabled", alarm2_irq, 0);
    wr(6'h18, 32'h1);
    check("R4 irq enabled", alarm2_irq, 1);
    wr(6'h1C, 32'h0);
    rd(6'h1C, d); check("R3 write0 keeps", d, 1);
    wr(6'h1C, 32'h1);
    rd(6'h1C, d); check("R3 write1 clears", d, 0);
    check("R4 irq after clear", alarm2_irq, 0);
    // R3: hit and clear in the same cycle
    @(negedge clk); alarm2_hit = 1'b1; reg_wr = 1'b1; reg_addr = 6'h1C; reg_wdata = 32'h1;
    @(negedge clk); alarm2_hit = 1'b0; reg_wr = 1'b0;
    rd(6'h1C, d); check("R3 set wins", d, 1);
    wr(6'h1C, 32'h1);

    // R5, R6, R7, R8: vector walk, power armed
    foreach (VEC[k]) begin
      wr(6'h20, {15'b0, 1'b1, 8'b0, VEC[k][8:5], VEC[k][12:9]});
      @(negedge clk); wake_pin = VEC[k][4:1];
      repeat (4) @(negedge clk);
      pulse_hit();
      if (!VEC[k][0]) check("R5 off after armed hit", pwr_en, 0);
      repeat (4) @(negedge clk);
      check(VEC[k][0] ? "R6 R7 wake on" : "R8 R7 stays off", pwr_en, 64'(VEC[k][0]));
    end

    // R6: exact latency, pin 0 active high
    wr(6'h20, 32'h0001_0001);
    @(negedge clk); wake_pin = 4'b0000;
    repeat (3) @(negedge clk);
    pulse_hit();
    check("R5 off", pwr_en, 0);
    @(negedge clk); wake_pin = 4'b0001;
    @(negedge clk); check("R6 edge1", pwr_en, 0);
    @(negedge clk); check("R6 edge2", pwr_en, 0);
    @(negedge clk); check("R6 edge3", pwr_en, 1);

    // R9: hit held with wake active keeps power off
    @(negedge clk); alarm2_hit = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 hit wins", pwr_en, 0);
    alarm2_hit = 1'b0;
    @(negedge clk); check("R9 on after hit", pwr_en, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule